// File: doc/BRIEF.md
# Interrupt-Banked Register File

This block is a 32-entry general register file with two read ports and one write port. Logical registers 0 to 15 have a single physical copy. Logical registers 16 to 31 each have two physical copies, called bank 0 and bank 1. A bank-select state decides which copy of the upper half every access uses. Register 0 is hardwired to zero.

The select rests on bank 1 during normal execution. An interrupt-entry strobe moves it to bank 0, so a handler gets sixteen private working registers and does not have to save or restore anything. An interrupt-return strobe moves it back to bank 1. Only one interrupt level may own bank 0 at a time. An entry that arrives while bank 0 is already selected leaves the select alone and raises a one-cycle error flag. Software can also set the select directly through a select-write input.

The storage sits in read-first memories with registered read data, so block RAM can be inferred. Each read port gets its own memory copy, and every copy receives the same write.

Top module: `banked_regfile`

## Requirements
- R1: After reset, `bank_sel` is 1, `nest_err` is 0, and both read data outputs are 0.
- R2: Reads are registered. An address presented in cycle N produces its data after the clock edge that ends cycle N. A read of the register being written in the same cycle returns the old contents.
- R3: Register 0 always reads as zero, and a write to it has no effect.
- R4: Registers 1 to 15 have a single copy. A value written while either bank is selected reads back the same under both banks.
- R5: Registers 16 to 31 have one copy per bank. A write updates only the copy of the bank selected in the write cycle, and the other bank's copy keeps its value.
- R6: `irq_enter` while `bank_sel` is 1 sets `bank_sel` to 0 from the next cycle on.
- R7: `irq_return` without `irq_enter` sets `bank_sel` to 1 from the next cycle on.
- R8: `irq_enter` while `bank_sel` is already 0 leaves `bank_sel` at 0 and drives `nest_err` high for exactly the next cycle. `nest_err` is low at all other times.
- R9: `sel_we` loads `sel_val` into `bank_sel` from the next cycle on. Priority is `irq_enter` first, then `irq_return`, then `sel_we`.
- R10: A write or read in the cycle in which the select changes uses the bank that was selected before the change.
- R11: The two read ports are independent. Each port returns the contents of its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A logical address |
| rd_addr_b | input | 5 | Read port B logical address |
| rd_data_a | output | 32 | Read port A data, registered |
| rd_data_b | output | 32 | Read port B data, registered |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write logical address |
| wr_data | input | 32 | Write data |
| irq_enter | input | 1 | Interrupt-entry strobe |
| irq_return | input | 1 | Interrupt-return strobe |
| sel_we | input | 1 | Software write of the bank select |
| sel_val | input | 1 | Value for the software select write |
| bank_sel | output | 1 | Current bank select (1 = normal, 0 = interrupt) |
| nest_err | output | 1 | One-cycle pulse on a nested interrupt entry |

## Verification
The hardest case to reach from the ports is an access that shares its cycle with a bank switch. In that cycle the strobe and the write address the same upper register, and only a later read under each bank shows which copy was written. The bench writes a distinct value into every register under both banks. It then switches banks, issuing a strobe together with a write to an upper register. Finally it sweeps all 32 addresses under each bank, with port B reading in reverse order, and compares every read against a bank-aware model. Nested entries and combined strobe and select writes cover the priority order.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  typedef enum logic {
    BANK_IRQ  = 1'b0,
    BANK_NORM = 1'b1
  } bank_e;

endpackage

// File: rtl/rf_ram_1w1r.sv
module rf_ram_1w1r #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 48,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Write-only process: no reset on storage so block RAM is inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-first: the output register samples the contents from before this edge's write.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
  import banked_rf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  irq_enter,
  input  logic  irq_return,
  input  logic  sel_we,
  input  logic  sel_val,
  output bank_e sel,
  output logic  nest_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= BANK_NORM;
      nest_err <= 1'b0;
    end else begin
      nest_err <= 1'b0;
      if (irq_enter) begin
        if (sel == BANK_IRQ) nest_err <= 1'b1;
        else                 sel      <= BANK_IRQ;
      end else if (irq_return) begin
        sel <= BANK_NORM;
      end else if (sel_we) begin
        sel <= bank_e'(sel_val);
      end
    end
  end

  assert_enter_sel_R6: assert property (@(posedge clk) disable iff (rst)
    irq_enter |=> sel == BANK_IRQ);

  assert_nested_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_enter && sel == BANK_IRQ) |=> nest_err);

  assert_flag_only_nested_R8: assert property (@(posedge clk) disable iff (rst)
    !(irq_enter && sel == BANK_IRQ) |=> !nest_err);

  assert_return_sel_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !irq_enter) |=> sel == BANK_NORM);

  assert_sw_sel_R9: assert property (@(posedge clk) disable iff (rst)
    (sel_we && !irq_enter && !irq_return) |=> sel == bank_e'($past(sel_val)));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!irq_enter && !irq_return && !sel_we) |=> $stable(sel));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_enter,
  input  logic              irq_return,
  input  logic              sel_we,
  input  logic              sel_val,
  output logic              bank_sel,
  output logic              nest_err
);

  localparam int NREG   = 1 << ADDR_W;
  localparam int HALF   = NREG / 2;
  localparam int PHYS   = NREG + HALF;   // lower half + two upper copies
  localparam int PA_W   = $clog2(PHYS);
  localparam int NPORTS = 2;

  bank_e sel;

  rf_bank_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .irq_enter (irq_enter),
    .irq_return(irq_return),
    .sel_we    (sel_we),
    .sel_val   (sel_val),
    .sel       (sel),
    .nest_err  (nest_err)
  );

  assign bank_sel = (sel == BANK_NORM);

  // Lower half maps 1:1; bank 0 upper copies follow, then bank 1 upper copies.
  function automatic logic [PA_W-1:0] phys_idx(input logic [ADDR_W-1:0] a, input bank_e b);
    logic [PA_W-1:0] p;
    if (a[ADDR_W-1])
      p = PA_W'(HALF) + ((b == BANK_NORM) ? PA_W'(HALF) : '0) + PA_W'(a[ADDR_W-2:0]);
    else
      p = PA_W'(a);
    return p;
  endfunction

  logic            wr_go;
  logic [PA_W-1:0] wr_pa;
  assign wr_go = wr_en && (wr_addr != '0);
  assign wr_pa = phys_idx(wr_addr, sel);

  logic [ADDR_W-1:0] rd_addr [NPORTS];
  logic [DATA_W-1:0] rd_raw  [NPORTS];
  logic [NPORTS-1:0] zero_q;
  assign rd_addr[0] = rd_addr_a;
  assign rd_addr[1] = rd_addr_b;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rf_ram_1w1r #(.DATA_W(DATA_W), .DEPTH(PHYS)) u_ram (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_go),
      .waddr(wr_pa),
      .wdata(wr_data),
      .raddr(phys_idx(rd_addr[p], sel)),
      .rdata(rd_raw[p])
    );

    always_ff @(posedge clk) begin
      if (rst) zero_q[p] <= 1'b1;
      else     zero_q[p] <= (rd_addr[p] == '0);
    end
  end

  assign rd_data_a = zero_q[0] ? '0 : rd_raw[0];
  assign rd_data_b = zero_q[1] ? '0 : rd_raw[1];

  assert_reg0_zero_a_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |=> rd_data_a == '0);

  assert_reg0_zero_b_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |=> rd_data_b == '0);

  assert_ports_agree_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == rd_addr_b) |=> rd_data_a == rd_data_b);

  assert_err_keeps_irq_bank_R8: assert property (@(posedge clk) disable iff (rst)
    nest_err |-> !bank_sel);

endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] rd_data_a, rd_data_b, wr_data;
  logic        wr_en, irq_enter, irq_return, sel_we, sel_val;
  logic        bank_sel, nest_err;

  always #2 clk = ~clk;   // 250 MHz

  banked_regfile uut (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_enter(irq_enter), .irq_return(irq_return),
    .sel_we(sel_we), .sel_val(sel_val),
    .bank_sel(bank_sel), .nest_err(nest_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;

  logic [31:0] m_lo [16];
  logic [31:0] m_up [2][16];
  logic        m_sel;

  function automatic logic [31:0] model_rd(input int r, input logic b);
    if (r == 0)  return 32'h0;
    if (r < 16)  return m_lo[r];
    return m_up[b][r-16];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Write under the current model bank; the model updates with the old select.
  task automatic do_write(input int r, input logic [31:0] v);
    wr_en = 1; wr_addr = 5'(r); wr_data = v;
    @(negedge clk);
    wr_en = 0;
    if (r != 0) begin
      if (r < 16) m_lo[r] = v;
      else        m_up[m_sel][r-16] = v;
    end
  endtask

  task automatic do_read(input int a, input int b, input string req);
    rd_addr_a = 5'(a); rd_addr_b = 5'(b);
    @(negedge clk);
    check(req, rd_data_a, model_rd(a, m_sel));
    check(req, rd_data_b, model_rd(b, m_sel));
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 32; r++) do_read(r, 31 - r, req);
  endtask

  function automatic logic [31:0] pat(input int r, input int tag);
    return 32'hC0DE_0000 | (32'(tag) << 8) | 32'(r);
  endfunction

  initial begin
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    rd_addr_a = 0; rd_addr_b = 0;
    irq_enter = 0; irq_return = 0; sel_we = 0; sel_val = 0;
    for (int i = 0; i < 16; i++) begin m_lo[i] = 'x; m_up[0][i] = 'x; m_up[1][i] = 'x; end
    m_sel = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 bank_sel", 32'(bank_sel), 32'd1);
    check("R1 nest_err", 32'(nest_err), 32'd0);
    check("R1 rd_data_a", rd_data_a, 32'd0);
    check("R1 rd_data_b", rd_data_b, 32'd0);
    rst = 0;
    @(negedge clk);

    // Fill all registers under bank 1, including attempt on register 0 (R3)
    for (int r = 0; r < 32; r++) do_write(r, pat(r, 1));
    sweep("R4/R5/R11 bank1");
    do_read(0, 0, "R3 reg0 zero");

    // R6 entry; also R10: write in switching cycle lands in bank 1
    irq_enter = 1; wr_en = 1; wr_addr = 5'd20; wr_data = 32'h5A5A_0020;
    rd_addr_a = 5'd21; rd_addr_b = 5'd3;
    @(negedge clk);
    irq_enter = 0; wr_en = 0;
    check("R10 read in switch cycle", rd_data_a, m_up[1][5]);
    m_up[1][4] = 32'h5A5A_0020;
    m_sel = 0;
    check("R6 bank_sel after entry", 32'(bank_sel), 32'd0);

    // Fill upper registers under bank 0, and rewrite a few lower ones
    for (int r = 16; r < 32; r++) do_write(r, pat(r, 2));
    do_write(7, 32'h0707_0707);
    do_write(0, 32'hFFFF_FFFF);
    sweep("R4/R5 bank0");

    // R2 read-first: read and write the same register in one cycle
    rd_addr_a = 5'd18; rd_addr_b = 5'd9;
    wr_en = 1; wr_addr = 5'd18; wr_data = 32'h1818_1818;
    @(negedge clk);
    wr_en = 0;
    check("R2 read-first", rd_data_a, m_up[0][2]);
    m_up[0][2] = 32'h1818_1818;
    do_read(18, 9, "R2 new value");

    // R8 nested entry
    irq_enter = 1;
    @(negedge clk);
    irq_enter = 0;
    check("R8 nest_err", 32'(nest_err), 32'd1);
    check("R8 bank_sel held", 32'(bank_sel), 32'd0);
    @(negedge clk);
    check("R8 nest_err one cycle", 32'(nest_err), 32'd0);

    // R7 return, R10 write in switching cycle lands in bank 0
    irq_return = 1; wr_en = 1; wr_addr = 5'd31; wr_data = 32'h3131_0000;
    @(negedge clk);
    irq_return = 0; wr_en = 0;
    m_up[0][15] = 32'h3131_0000;
    m_sel = 1;
    check("R7 bank_sel after return", 32'(bank_sel), 32'd1);
    check("R8 no err on return", 32'(nest_err), 32'd0);
    sweep("R4/R5/R10 back in bank1");

    // R9 priority: enter beats sel_we=1
    irq_enter = 1; sel_we = 1; sel_val = 1;
    @(negedge clk);
    irq_enter = 0; sel_we = 0;
    check("R9 enter over sel_we", 32'(bank_sel), 32'd0);
    // return beats sel_we=0
    irq_return = 1; sel_we = 1; sel_val = 0;
    @(negedge clk);
    irq_return = 0; sel_we = 0;
    check("R9 return over sel_we", 32'(bank_sel), 32'd1);
    // enter beats return
    irq_enter = 1; irq_return = 1;
    @(negedge clk);
    irq_enter = 0; irq_return = 0;
    check("R9 enter over return", 32'(bank_sel), 32'd0);
    // software select alone
    sel_we = 1; sel_val = 1;
    @(negedge clk);
    sel_we = 0;
    check("R9 sw select 1", 32'(bank_sel), 32'd1);
    sel_we = 1; sel_val = 0;
    @(negedge clk);
    sel_we = 0;
    m_sel = 0;
    check("R9 sw select 0", 32'(bank_sel), 32'd0);
    sweep("R9/R5 sw selected bank0");
    check("R8 no spurious err", 32'(nest_err), 32'd0);

    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule